// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration bitstream into an SRAM-based programmable device through its slave-serial pins. A single `start` pulse opens the sequence. The block pulls the active-low reset pin (`cfg_prog_n`) low for a fixed time and then releases it. It then waits for the target to report, on its ready pin (`cfg_init`), that its memory is clear. After a guard delay it begins taking payload bytes from a valid/ready stream. Each byte leaves on `cfg_dout` one bit at a time, most significant bit first, with exactly one rising edge of `cfg_cclk` per bit.

The target counts clock edges against a length field inside the stream, so the serial clock is gated: it stays low in every state except while a bit is actually in flight. The data pin moves only while the clock is low. The block does not parse the bitstream. The caller supplies the leading ones, the sync pattern and the length field as ordinary payload bytes.

Back-pressure: `s_ready` depends only on internal state and never on `s_valid`. A byte is taken on a clock edge where both signals are high. While `s_valid` is low the clock simply stays low, so gaps in the stream cost time but add no edges. The byte marked with `s_last` is the final one, and `s_ready` stays low after it has been taken. The ready pin is asynchronous and passes through a two-stage synchronizer. The pulse width, guard delay, clock half-period and ready timeout are parameters counted in system-clock cycles.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, `cfg_prog_n` is 1, `cfg_cclk` is 0, and `busy`, `done`, `timeout` and `s_ready` are all 0.
- R2: A `start` pulse while idle makes `busy` high on the next cycle and drives `cfg_prog_n` low for exactly PROG_CYC cycles. A `start` while busy is ignored and produces no second low pulse.
- R3: After `cfg_prog_n` is released, the block holds `cfg_cclk` low and `s_ready` low, with `busy` high, until the synchronized `cfg_init` is seen high.
- R4: If `cfg_init` stays low for INIT_TMO_CYC cycles after the release, `timeout` is set and `busy` falls together, exactly 1+PROG_CYC+INIT_TMO_CYC cycles after the `start` cycle. No clock edge is produced.
- R5: The first `cfg_cclk` rising edge comes no earlier than GUARD_CYC+2 cycles after `cfg_init` goes high at the pin.
- R6: `s_ready` is high only while streaming, with no byte in flight and the last byte not yet taken. A byte is taken on `s_valid && s_ready`. After the `s_last` byte, further valid data is not taken.
- R7: Bits leave most significant bit first. `cfg_dout` is sampled by the target on each `cfg_cclk` rising edge. The low and high phases of `cfg_cclk` each last HALF_CYC cycles.
- R8: `cfg_dout` changes only while `cfg_cclk` is low. It is stable at each rising edge and throughout every high phase.
- R9: `cfg_cclk` stays low whenever no bit is in flight, including stream gaps and idle. A load of N bytes produces exactly 8*N rising edges.
- R10: `done` rises, and `busy` falls, after the last bit's falling clock edge, with `cfg_cclk` low. `done` and `timeout` are never both high. Each holds until the next accepted `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a configuration sequence |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | DW | Payload byte, sent most significant bit first |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Block can take a payload byte |
| cfg_prog_n | output | 1 | Active-low reset pulse to the target |
| cfg_init | input | 1 | Target ready indication, asynchronous |
| cfg_cclk | output | 1 | Gated serial clock to the target |
| cfg_dout | output | 1 | Serial data to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last bit delivered |
| timeout | output | 1 | Target never signalled ready |

## Verification
The bench builds the block with PROG_CYC=5, GUARD_CYC=8, HALF_CYC=2 and INIT_TMO_CYC=40. These values let a run reach the ready timeout and the guard boundary within a few dozen cycles, so both can be checked at exact cycle counts. A half-period of two makes every clock phase span more than one system cycle, so data that moved in the middle of a high phase would show up. Loads of one, four and six bytes are run, with and without stream gaps, with late ready indications, and with a stray start during streaming.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_GUARD  = 3'd3,
    ST_STREAM = 3'd4
  } cfgld_state_e;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int PROG_CYC     = 200,
  parameter int GUARD_CYC    = 600,
  parameter int INIT_TMO_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic init_i,
  input  logic fin_i,
  output logic prog_n_o,
  output logic stream_o,
  output logic busy_o,
  output logic done_o,
  output logic tmo_o
);
  localparam int MAX_AB = (PROG_CYC > GUARD_CYC) ? PROG_CYC : GUARD_CYC;
  localparam int MAX_C  = (MAX_AB > INIT_TMO_CYC) ? MAX_AB : INIT_TMO_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] PROG_LIM  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] GUARD_LIM = CW'(GUARD_CYC - 1);
  localparam logic [CW-1:0] TMO_LIM   = CW'(INIT_TMO_CYC - 1);

  cfgld_state_e    state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      prog_n_o <= 1'b1;
      done_o   <= 1'b0;
      tmo_o    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_PROG;
            cnt      <= '0;
            prog_n_o <= 1'b0;
            done_o   <= 1'b0;
            tmo_o    <= 1'b0;
          end
        end
        ST_PROG: begin
          if (cnt == PROG_LIM) begin
            state    <= ST_WAIT;
            cnt      <= '0;
            prog_n_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (init_i) begin
            state <= ST_GUARD;
            cnt   <= '0;
          end else if (cnt == TMO_LIM) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tmo_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (cnt == GUARD_LIM) begin
            state <= ST_STREAM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STREAM: begin
          if (fin_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stream_o = (state == ST_STREAM);
  assign busy_o   = (state != ST_IDLE);
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
  parameter int DW       = 8,
  parameter int HALF_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          cclk_o,
  output logic          dout_o,
  output logic          fin_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam logic [HW-1:0] HLIM    = HW'(HALF_CYC - 1);
  localparam logic [BW-1:0] BIT_TOP = BW'(DW - 1);

  logic [DW-1:0] sreg;
  logic [BW-1:0] bitcnt;
  logic [HW-1:0] hcnt;
  logic          full;
  logic          last_taken;
  logic          last_in_reg;

  assign s_ready = en_i && !full && !last_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg        <= '0;
      bitcnt      <= '0;
      hcnt        <= '0;
      full        <= 1'b0;
      last_taken  <= 1'b0;
      last_in_reg <= 1'b0;
      cclk_o      <= 1'b0;
      dout_o      <= 1'b0;
      fin_o       <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!en_i) begin
        full       <= 1'b0;
        last_taken <= 1'b0;
        cclk_o     <= 1'b0;
        hcnt       <= '0;
      end else if (!full) begin
        if (s_valid && s_ready) begin
          full        <= 1'b1;
          sreg        <= s_data;
          dout_o      <= s_data[DW-1];
          bitcnt      <= '0;
          hcnt        <= '0;
          last_in_reg <= s_last;
          last_taken  <= s_last;
        end
      end else if (!cclk_o) begin
        if (hcnt == HLIM) begin
          cclk_o <= 1'b1;
          hcnt   <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end else begin
        if (hcnt == HLIM) begin
          cclk_o <= 1'b0;
          hcnt   <= '0;
          if (bitcnt == BIT_TOP) begin
            full  <= 1'b0;
            fin_o <= last_in_reg;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sreg   <= {sreg[DW-2:0], 1'b0};
            dout_o <= sreg[DW-2];
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int DW           = 8,
  parameter int PROG_CYC     = 200,
  parameter int GUARD_CYC    = 600,
  parameter int HALF_CYC     = 5,
  parameter int INIT_TMO_CYC = 100000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          cfg_prog_n,
  input  logic          cfg_init,
  output logic          cfg_cclk,
  output logic          cfg_dout,
  output logic          busy,
  output logic          done,
  output logic          timeout
);
  logic init_s;
  logic stream_en;
  logic fin;

  cfgld_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (cfg_init),
    .q_o  (init_s)
  );

  cfgld_seq #(
    .PROG_CYC    (PROG_CYC),
    .GUARD_CYC   (GUARD_CYC),
    .INIT_TMO_CYC(INIT_TMO_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .init_i  (init_s),
    .fin_i   (fin),
    .prog_n_o(cfg_prog_n),
    .stream_o(stream_en),
    .busy_o  (busy),
    .done_o  (done),
    .tmo_o   (timeout)
  );

  cfgld_shift #(.DW(DW), .HALF_CYC(HALF_CYC)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (stream_en),
    .s_valid(s_valid),
    .s_data (s_data),
    .s_last (s_last),
    .s_ready(s_ready),
    .cclk_o (cfg_cclk),
    .dout_o (cfg_dout),
    .fin_o  (fin)
  );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int HALF_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic s_ready,
  input logic cfg_prog_n,
  input logic cfg_cclk,
  input logic cfg_dout,
  input logic busy,
  input logic done,
  input logic timeout
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= 0;
    else if (cfg_cclk) hi_cnt <= hi_cnt + 1;
    else               hi_cnt <= 0;
  end

  // R2: the reset pulse only occurs inside a busy sequence
  p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> busy);

  // R3: no serial clock while the target is held in reset
  p_cclk_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_cclk);

  // R4: timeout rises together with the return to idle
  p_tmo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> !busy);

  // R6: ready only while the link is up and the clock is low
  p_ready_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && cfg_prog_n && !cfg_cclk));

  // R7: each high phase lasts exactly HALF_CYC cycles
  p_high_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_cclk) |-> (hi_cnt == HALF_CYC));

  // R8: data is steady over the rising edge and the high phase
  p_data_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_dout));
  p_data_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_dout));

  // R9: the clock is quiet outside a sequence
  p_cclk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_cclk);

  // R10: completion flags are exclusive and only seen while idle
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cfg_cclk));
endmodule

bind cfg_serial_loader cfgld_checker #(.HALF_CYC(HALF_CYC)) u_cfgld_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready   (s_ready),
  .cfg_prog_n(cfg_prog_n),
  .cfg_cclk  (cfg_cclk),
  .cfg_dout  (cfg_dout),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int PROG  = 5;
  localparam int GUARD = 8;
  localparam int HALF  = 2;
  localparam int TMO   = 40;
  localparam int WD_CYCLES = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic          s_ready;
  logic          cfg_prog_n;
  logic          cfg_init = 1'b0;
  logic          cfg_cclk;
  logic          cfg_dout;
  logic          busy;
  logic          done;
  logic          timeout;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc = 0;
  bit exp_q[$];
  int rises = 0;
  int first_rise_cyc = -1;
  int init_cyc = 0;
  int plow = 0;
  int last_plow = 0;
  int pfalls = 0;
  logic cclk_q = 1'b0;
  logic dout_q = 1'b0;
  logic prog_q = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  cfg_serial_loader #(
    .DW(DW), .PROG_CYC(PROG), .GUARD_CYC(GUARD),
    .HALF_CYC(HALF), .INIT_TMO_CYC(TMO), .SYNC_STAGES(2)
  ) i_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_init(cfg_init), .cfg_cclk(cfg_cclk),
    .cfg_dout(cfg_dout), .busy(busy), .done(done), .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int seed);
    if (i == 0) return 8'hFF;
    if (i == 1) return 8'h2F;
    return DW'((i * 73 + seed * 29 + 92) ^ (i << 4));
  endfunction

  // Monitor / scoreboard: sampled on falling system-clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_cclk && !cclk_q) begin
        rises++;
        if (first_rise_cyc < 0) first_rise_cyc = cyc;
        check(cfg_dout == dout_q, "R8 data moved at rising edge", cfg_dout, dout_q);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected extra clock edge", rises, rises - 1);
        end else begin
          automatic bit b = exp_q.pop_front();
          check(cfg_dout == b, "R7 serial bit order", cfg_dout, b);
        end
      end
      if (cfg_cclk && cclk_q)
        check(cfg_dout == dout_q, "R8 data moved in high phase", cfg_dout, dout_q);
      if (!cfg_prog_n) plow++;
      if (cfg_prog_n && !prog_q) begin last_plow = plow; plow = 0; end
      if (!cfg_prog_n && prog_q) pfalls++;
    end
    cclk_q = cfg_cclk;
    dout_q = cfg_dout;
    prog_q = cfg_prog_n;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Driver: pushes expected bits, runs one full load
  task automatic run_load(input int nbytes, input int gap, input int init_delay,
                          input int seed, input bit stray_start);
    int wait_n;
    for (int i = 0; i < nbytes; i++) begin
      automatic logic [DW-1:0] v = pat(i, seed);
      for (int k = DW - 1; k >= 0; k--) exp_q.push_back(v[k]);
    end
    rises = 0; first_rise_cyc = -1; pfalls = 0;
    pulse_start();
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(cfg_prog_n == 1'b0, "R2 reset pulse low", cfg_prog_n, 0);
    check(done == 1'b0, "R10 done cleared by start", done, 0);
    check(timeout == 1'b0, "R10 timeout cleared by start", timeout, 0);
    while (!cfg_prog_n) @(negedge clk);
    @(negedge clk);
    check(last_plow == PROG, "R2 reset pulse width", last_plow, PROG);
    repeat (init_delay) @(negedge clk);
    check(busy && cfg_prog_n && !cfg_cclk && !s_ready, "R3 waiting for ready pin",
          {busy, cfg_prog_n, cfg_cclk, s_ready}, 4'b1100);
    cfg_init = 1'b1;
    init_cyc = cyc;
    for (int i = 0; i < nbytes; i++) begin
      repeat (gap) @(negedge clk);
      s_valid = 1'b1;
      s_data  = pat(i, seed);
      s_last  = (i == nbytes - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      if (stray_start && i == 1) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      s_valid = 1'b0;
    end
    // junk after the last byte must not be taken
    s_valid = 1'b1; s_data = 8'hA5; s_last = 1'b0;
    @(negedge clk);
    check(s_ready == 1'b0, "R6 ready low after last byte", s_ready, 0);
    wait_n = 0;
    while (!done && wait_n < 4000) begin @(negedge clk); wait_n++; end
    s_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R10 done asserted", done, 1);
    check(busy == 1'b0 && cfg_cclk == 1'b0, "R10 idle with clock low after done",
          {busy, cfg_cclk}, 0);
    check(rises == DW * nbytes, "R9 exact clock edge count", rises, DW * nbytes);
    check(exp_q.size() == 0, "R7 all bits delivered", exp_q.size(), 0);
    check(first_rise_cyc - init_cyc >= GUARD + 2, "R5 guard before first edge",
          first_rise_cyc - init_cyc, GUARD + 2);
    check(pfalls == 1, "R2 stray start ignored", pfalls, 1);
    check(s_ready == 1'b0, "R6 ready low when idle", s_ready, 0);
    cfg_init = 1'b0;
    exp_q.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic run_timeout();
    int k;
    rises = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R10 done cleared by start", done, 0);
    k = 1;
    while (!timeout && k < 1000) begin @(negedge clk); k++; end
    check(k == 1 + PROG + TMO, "R4 timeout cycle", k, 1 + PROG + TMO);
    check(busy == 1'b0, "R4 idle after timeout", busy, 0);
    check(last_plow == PROG, "R2 reset pulse width", last_plow, PROG);
    check(rises == 0, "R4 no clock edges without ready", rises, 0);
    check(s_ready == 1'b0, "R6 ready low after timeout", s_ready, 0);
    repeat (3) @(negedge clk);
    check(timeout == 1'b1 && done == 1'b0, "R10 timeout held, done low",
          {timeout, done}, 2'b10);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    check(cfg_prog_n == 1'b1 && cfg_cclk == 1'b0, "R1 pins in reset",
          {cfg_prog_n, cfg_cclk}, 2'b10);
    check(!busy && !done && !timeout && !s_ready, "R1 status in reset",
          {busy, done, timeout, s_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cfg_prog_n == 1'b1 && !busy && !cfg_cclk, "R1 idle after reset",
          {cfg_prog_n, busy, cfg_cclk}, 3'b100);

    run_load(4, 0, 3, 1, 1'b0);
    run_timeout();
    run_load(6, 3, 10, 2, 1'b1);
    run_load(1, 1, 0, 3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule